// File: doc/BRIEF.md
# I2C Slave Bus Status Tracker

This block is the receive and respond side of an I2C target device. It samples the SDA and SCL wires through synchronizer flops on the system clock. It recognises start and stop conditions and shifts in each byte on the SCL rising edges. It compares the first byte of a transfer against an own address of 7 bits, or runs a two-byte 10-bit address match. Once addressed, it acknowledges by pulling SDA low. It also shifts a byte from its buffer onto SDA when the master reads.

The host side loads the own-address register, and reads or writes a one-byte buffer. It watches six status flags: start seen, stop seen, data/address, read/write, update-address and buffer-full. The block drives only an active-high "pull SDA low" output. The open-drain pad and its pull-up sit outside. Clock stretching, general call and master operation are not part of it.

Top module: `i2c_slv_track`

## Requirements
- R1: SDA falling while SCL is high sets `st_start` and clears `st_stop`. The two flags are never set together.
- R2: SDA rising while SCL is high sets `st_stop` and clears `st_start`. After reset every status flag and `sda_low` read 0.
- R3: In 7-bit mode, the slave acknowledges an address byte whose bits 7..1 equal own-address bits 7..1. It holds `sda_low` high through the ninth SCL clock and releases it at the following SCL fall. After an address byte, `st_da` reads 0.
- R4: On an address match, `st_rw` takes bit 0 of the address byte (1 = read, 0 = write). A non-matching address leaves `st_rw` unchanged.
- R5: In an addressed write, each data byte received while the buffer is empty is acknowledged and lands in `buf_rdata`. It also sets `st_full` and `st_da`.
- R6: A data byte that arrives while `st_full` is set is not acknowledged, and the buffer keeps its old value. A one-cycle `buf_rd` pulse clears `st_full`.
- R7: After a non-matching address, that byte and the following bytes up to the next start are neither acknowledged nor stored.
- R8: In a read transfer, a `buf_wr` pulse sets `st_full`. At the ninth SCL fall the buffer byte is driven MSB first, and `st_full` clears at the eighth SCL rise of that byte. A master ACK (SDA low at the ninth clock) continues with the buffer contents. A NACK ends the transfer.
- R9: In 10-bit mode, a header byte 11110 a9 a8 0 whose bits 7..1 equal own-address bits 7..1 is acknowledged and sets `st_upd`. An `adr_we` write clears `st_upd`. A following byte equal to the full own-address register is acknowledged and sets `st_upd` again. Any other second byte is not acknowledged.
- R10: In 10-bit mode, a repeated start whose header has direction 1 is acknowledged and begins transmit only after a completed 10-bit write match with no stop in between. Otherwise it is not acknowledged.
- R11: While `en` is low, `st_start` and `st_stop` are cleared, `sda_low` is 0 and bus activity is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable |
| ten_bit | input | 1 | 1 selects two-byte 10-bit addressing |
| scl_in | input | 1 | SCL wire level, asynchronous |
| sda_in | input | 1 | SDA wire level, asynchronous |
| sda_low | output | 1 | 1 pulls SDA low (ACK or a 0 data bit) |
| adr_we | input | 1 | Write strobe for the own-address register |
| adr_wdata | input | 8 | Own-address write value |
| buf_wr | input | 1 | Host write strobe for the buffer |
| buf_wdata | input | 8 | Buffer write value |
| buf_rd | input | 1 | Host read strobe, clears buffer-full |
| buf_rdata | output | 8 | Buffer contents |
| st_start | output | 1 | Start was the last bus condition |
| st_stop | output | 1 | Stop was the last bus condition |
| st_da | output | 1 | Last byte moved was data (1) or address (0) |
| st_rw | output | 1 | Direction bit of the last matched address |
| st_upd | output | 1 | Host must load the next address byte |
| st_full | output | 1 | Buffer holds an unread byte or one being sent |

## Verification
The hardest situation to reach is the 10-bit read. A header-only read is accepted only after a full two-byte write match has been seen with no stop in between. The host must also rewrite the own-address register twice inside the address phase. The bench walks this sequence directly: header, low-byte reload, low byte, header reload, data, then a repeated start. It then repeats the header read after a stop, where it must be refused. The buffer hand-off during a read is reached by forking the bus master against a host write timed between the eighth SCL rise and the ninth SCL fall.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_LOW,
    PH_RX,
    PH_TX
  } phase_t;
endpackage

// File: rtl/i2cst_front.sv
module i2cst_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_i,
  input  logic scl_i,
  output logic sda_l,
  output logic scl_l,
  output logic start_e,
  output logic stop_e,
  output logic rise_e,
  output logic fall_e
);
  logic [STAGES-1:0] sda_pipe;
  logic [STAGES-1:0] scl_pipe;
  logic sda_now;
  logic scl_now;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          sda_pipe <= '1;
          scl_pipe <= '1;
        end else begin
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          sda_pipe <= '1;
          scl_pipe <= '1;
        end else begin
          sda_pipe <= sda_i;
          scl_pipe <= scl_i;
        end
      end
    end
  endgenerate

  assign sda_now = sda_pipe[STAGES-1];
  assign scl_now = scl_pipe[STAGES-1];

  // Events are registered together with the line levels they refer to.
  always_ff @(posedge clk) begin
    if (rst) begin
      sda_l   <= 1'b1;
      scl_l   <= 1'b1;
      start_e <= 1'b0;
      stop_e  <= 1'b0;
      rise_e  <= 1'b0;
      fall_e  <= 1'b0;
    end else begin
      sda_l   <= sda_now;
      scl_l   <= scl_now;
      start_e <= scl_now & scl_l & sda_l & ~sda_now;
      stop_e  <= scl_now & scl_l & ~sda_l & sda_now;
      rise_e  <= scl_now & ~scl_l;
      fall_e  <= ~scl_now & scl_l;
    end
  end
endmodule

// File: rtl/i2cst_match.sv
module i2cst_match
  import i2cst_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic [BW-1:0] rx_byte,
  input  logic [BW-1:0] own,
  input  logic          ten_bit,
  input  phase_t        ph,
  input  logic          ten_done,
  output logic          hit,
  output logic          to_low
);
  localparam logic [4:0] HDR_TAG = 5'b11110;

  logic is_hdr;
  logic upper_eq;

  assign is_hdr   = (rx_byte[BW-1 -: 5] == HDR_TAG);
  assign upper_eq = (rx_byte[BW-1:1] == own[BW-1:1]);

  always_comb begin
    hit    = 1'b0;
    to_low = 1'b0;
    unique case (ph)
      PH_ADDR: begin
        if (!ten_bit) begin
          hit = upper_eq;
        end else if (is_hdr && upper_eq) begin
          if (!rx_byte[0]) begin
            hit    = 1'b1;
            to_low = 1'b1;
          end else begin
            hit = ten_done;
          end
        end
      end
      PH_LOW:  hit = (rx_byte == own);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_slv_track.sv
module i2c_slv_track
  import i2cst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ten_bit,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_low,
  input  logic              adr_we,
  input  logic [BYTE_W-1:0] adr_wdata,
  input  logic              buf_wr,
  input  logic [BYTE_W-1:0] buf_wdata,
  input  logic              buf_rd,
  output logic [BYTE_W-1:0] buf_rdata,
  output logic              st_start,
  output logic              st_stop,
  output logic              st_da,
  output logic              st_rw,
  output logic              st_upd,
  output logic              st_full
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] END_SLOT = CNT_W'(BYTE_W + 1);

  logic sda_l, scl_l, start_e, stop_e, rise_e, fall_e;
  logic [BYTE_W-1:0] shreg, txsh, buf_q, own_q, byte_now;
  logic [CNT_W-1:0]  cnt;
  phase_t            ph;
  logic              ack_pend, ten_done;
  logic              m_hit, m_to_low;

  i2cst_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .sda_i(sda_in), .scl_i(scl_in),
    .sda_l(sda_l), .scl_l(scl_l), .start_e(start_e), .stop_e(stop_e),
    .rise_e(rise_e), .fall_e(fall_e)
  );

  assign byte_now = {shreg[BYTE_W-2:0], sda_l};

  i2cst_match #(.BW(BYTE_W)) u_match (
    .rx_byte(byte_now), .own(own_q), .ten_bit(ten_bit), .ph(ph),
    .ten_done(ten_done), .hit(m_hit), .to_low(m_to_low)
  );

  assign buf_rdata = buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE;     cnt <= '0;       shreg <= '0;     txsh <= '0;
      buf_q <= '0;       own_q <= '0;     sda_low <= 1'b0; ack_pend <= 1'b0;
      ten_done <= 1'b0;  st_start <= 1'b0; st_stop <= 1'b0; st_da <= 1'b0;
      st_rw <= 1'b0;     st_upd <= 1'b0;  st_full <= 1'b0;
    end else begin
      if (!en) begin
        ph       <= PH_IDLE;
        cnt      <= '0;
        sda_low  <= 1'b0;
        ack_pend <= 1'b0;
        ten_done <= 1'b0;
        st_start <= 1'b0;
        st_stop  <= 1'b0;
      end else if (start_e) begin
        st_start <= 1'b1;
        st_stop  <= 1'b0;
        ph       <= PH_ADDR;
        cnt      <= '0;
        sda_low  <= 1'b0;
        ack_pend <= 1'b0;
      end else if (stop_e) begin
        st_stop  <= 1'b1;
        st_start <= 1'b0;
        ph       <= PH_IDLE;
        ten_done <= 1'b0;
        sda_low  <= 1'b0;
        ack_pend <= 1'b0;
      end else begin
        // SCL rising: shift a bit in, judge a completed byte, read master ACK
        if (rise_e && ph != PH_IDLE) begin
          if (cnt < ACK_SLOT) begin
            shreg <= byte_now;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              unique case (ph)
                PH_ADDR, PH_LOW: begin
                  if (m_hit) begin
                    ack_pend <= 1'b1;
                    st_da    <= 1'b0;
                    if (ph == PH_ADDR) st_rw <= byte_now[0];
                    if (m_to_low) begin
                      ph       <= PH_LOW;
                      st_upd   <= 1'b1;
                      ten_done <= 1'b0;
                    end else if (ph == PH_LOW) begin
                      ph       <= PH_RX;
                      st_upd   <= 1'b1;
                      ten_done <= 1'b1;
                    end else if (byte_now[0]) begin
                      ph <= PH_TX;
                    end else begin
                      ph <= PH_RX;
                    end
                  end else begin
                    ph <= PH_IDLE;
                  end
                end
                PH_RX: begin
                  if (!st_full) begin
                    buf_q    <= byte_now;
                    st_full  <= 1'b1;
                    st_da    <= 1'b1;
                    ack_pend <= 1'b1;
                  end
                end
                PH_TX: begin
                  st_full <= 1'b0;
                  st_da   <= 1'b1;
                end
                default: ;
              endcase
            end
          end else if (cnt == ACK_SLOT) begin
            cnt <= END_SLOT;
            if (ph == PH_TX && !ack_pend && sda_l) ph <= PH_IDLE;
          end
        end
        // SCL falling: place ACK, release it, or present the next data bit
        if (fall_e) begin
          if (cnt == ACK_SLOT) begin
            sda_low <= ack_pend;
          end else if (cnt == END_SLOT) begin
            cnt      <= '0;
            ack_pend <= 1'b0;
            if (ph == PH_TX) begin
              sda_low <= ~buf_q[BYTE_W-1];
              txsh    <= buf_q;
            end else begin
              sda_low <= 1'b0;
            end
          end else if (ph == PH_TX && cnt != '0) begin
            sda_low <= ~txsh[BYTE_W-2];
            txsh    <= txsh << 1;
          end
        end
      end

      // host side
      if (buf_wr) begin
        buf_q <= buf_wdata;
        if (en && ph == PH_TX) st_full <= 1'b1;
      end
      if (buf_rd) st_full <= 1'b0;
      if (adr_we) begin
        own_q  <= adr_wdata;
        st_upd <= 1'b0;
      end
    end
  end

  // R1
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(st_start && st_stop));

  // R3
  drive_on_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> !$past(scl_l));

  // R6
  full_holds_buf_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st_full) && !$past(buf_wr) && $past(ph) != PH_TX) |-> $stable(buf_q));

  // R9
  upd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    adr_we |=> !st_upd);

  // R11
  disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sda_low && !st_start && !st_stop));
endmodule

// File: tb/i2c_slv_track_bench.sv
module i2c_slv_track_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, en, ten_bit, m_sda, m_scl, sda_low;
  logic adr_we, buf_wr, buf_rd;
  logic [7:0] adr_wdata, buf_wdata, buf_rdata;
  logic st_start, st_stop, st_da, st_rw, st_upd, st_full;
  wire  bus_sda = m_sda & ~sda_low;

  int n_run = 0;
  int n_fail = 0;

  i2c_slv_track u_i2c_slv_track (
    .clk(clk), .rst(rst), .en(en), .ten_bit(ten_bit), .scl_in(m_scl),
    .sda_in(bus_sda), .sda_low(sda_low), .adr_we(adr_we), .adr_wdata(adr_wdata),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
    .st_start(st_start), .st_stop(st_stop), .st_da(st_da), .st_rw(st_rw),
    .st_upd(st_upd), .st_full(st_full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic match7(input logic [7:0] b, input logic [7:0] own);
    return b[7:1] == own[7:1];
  endfunction

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic bstart();
    m_sda = 1; qwait(); m_scl = 1; qwait(); m_sda = 0; qwait(); m_scl = 0; qwait();
  endtask

  task automatic bstop();
    m_sda = 0; qwait(); m_scl = 1; qwait(); m_sda = 1; qwait();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qwait(); m_scl = 1; qwait(); m_scl = 0; qwait();
    end
    m_sda = 1; qwait(); m_scl = 1; qwait(); acked = !bus_sda; m_scl = 0; qwait();
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1; qwait(); m_scl = 1; qwait(); d[i] = bus_sda; m_scl = 0; qwait();
    end
    m_sda = !mack; qwait(); m_scl = 1; qwait(); m_scl = 0; qwait(); m_sda = 1;
  endtask

  task automatic host_adr(input logic [7:0] v);
    adr_wdata = v; adr_we = 1; @(negedge clk); adr_we = 0; @(negedge clk);
  endtask
  task automatic host_wr(input logic [7:0] v);
    buf_wdata = v; buf_wr = 1; @(negedge clk); buf_wr = 0; @(negedge clk);
  endtask
  task automatic host_rd();
    buf_rd = 1; @(negedge clk); buf_rd = 0; @(negedge clk);
  endtask

  logic ack;
  logic [7:0] got, d0, d1, mbuf;
  logic mfull;
  localparam logic [7:0] OWN7 = {7'h2A, 1'b0};
  localparam logic [7:0] HDR  = {5'b11110, 2'b10, 1'b0};
  localparam logic [7:0] LOWB = 8'h5C;

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    rst = 1; en = 0; ten_bit = 0; m_sda = 1; m_scl = 1;
    adr_we = 0; buf_wr = 0; buf_rd = 0; adr_wdata = 0; buf_wdata = 0;
    repeat (5) @(negedge clk);
    rst = 0; @(negedge clk);
    // R2 reset state
    chk("R2 reset flags", {st_start, st_stop, st_da, st_rw, st_upd, st_full, sda_low}, 0);

    en = 1;
    host_adr(OWN7);
    bstart();
    chk("R1 start flag", {st_start, st_stop}, 2'b10);
    wbyte(OWN7, ack);
    chk("R3 addr ack", ack, 1);
    chk("R3 ack released", sda_low, 0);
    chk("R3 da after addr", st_da, 0);
    chk("R4 rw write", st_rw, 0);
    d0 = 8'($urandom());
    wbyte(d0, ack);
    chk("R5 data ack", ack, 1);
    chk("R5 buffer", buf_rdata, d0);
    chk("R5 full/da", {st_full, st_da}, 2'b11);
    d1 = ~d0;
    wbyte(d1, ack);
    chk("R6 nack when full", ack, 0);
    chk("R6 buffer kept", buf_rdata, d0);
    host_rd();
    chk("R6 read clears full", st_full, 0);
    bstop();
    chk("R2 stop flag", {st_start, st_stop}, 2'b01);

    // R7 mismatched read address, then bytes ignored
    bstart();
    wbyte({7'h2B, 1'b1}, ack);
    chk("R7 no ack", ack, 0);
    chk("R4 rw unchanged", st_rw, 0);
    wbyte(8'h00, ack);
    chk("R7 data ignored ack", ack, 0);
    chk("R7 data ignored full", st_full, 0);
    chk("R7 buffer kept", buf_rdata, d0);
    bstop();

    // R8 read transfer
    d0 = 8'($urandom()); d1 = 8'($urandom());
    bstart();
    fork
      wbyte({7'h2A, 1'b1}, ack);
      begin repeat (24 * Q) @(negedge clk); host_wr(d0); end
    join
    chk("R8 read addr ack", ack, 1);
    chk("R4 rw read", st_rw, 1);
    chk("R8 full after write", st_full, 1);
    fork
      rbyte(1'b1, got);
      begin
        repeat (23 * Q) @(negedge clk);
        chk("R8 full clears on 8th rise", st_full, 0);
        host_wr(d1);
      end
    join
    chk("R8 first byte", got, d0);
    chk("R8 full for next", st_full, 1);
    rbyte(1'b0, got);
    chk("R8 second byte", got, d1);
    chk("R8 full cleared", st_full, 0);
    bstop();
    chk("R8 released after nack", sda_low, 0);

    // random write transfers against a bench model
    mbuf = buf_rdata; mfull = st_full;
    for (int it = 0; it < 12; it++) begin
      logic [7:0] a;
      logic hitm;
      int nb;
      a = ($urandom() % 2 == 0) ? OWN7 : (OWN7 ^ {7'(1 + $urandom() % 127), 1'b0});
      hitm = match7(a, OWN7);
      nb = 1 + int'($urandom() % 3);
      bstart();
      wbyte(a, ack);
      chk("R3 random addr ack", ack, hitm);
      for (int k = 0; k < nb; k++) begin
        logic [7:0] dv;
        logic expa;
        dv = 8'($urandom());
        expa = hitm && !mfull;
        if (expa) begin mbuf = dv; mfull = 1; end
        wbyte(dv, ack);
        chk(hitm ? "R5 random data ack" : "R7 random data ack", ack, expa);
        chk("R6 random buffer", buf_rdata, mbuf);
        chk("R6 random full", st_full, mfull);
        if ($urandom() % 4 != 0) begin host_rd(); mfull = 0; end
      end
      bstop();
      host_rd(); mfull = 0;
    end

    // R9 10-bit write
    ten_bit = 1;
    host_adr(HDR);
    bstart();
    wbyte(HDR, ack);
    chk("R9 header ack", ack, 1);
    chk("R9 upd set", st_upd, 1);
    host_adr(LOWB);
    chk("R9 upd cleared", st_upd, 0);
    wbyte(LOWB, ack);
    chk("R9 low ack", ack, 1);
    chk("R9 upd again", st_upd, 1);
    host_adr(HDR);
    d0 = 8'($urandom());
    wbyte(d0, ack);
    chk("R5 10-bit data", {ack, buf_rdata}, {1'b1, d0});
    host_rd();
    // R10 repeated start read
    d1 = 8'($urandom());
    bstart();
    fork
      wbyte(HDR | 8'h01, ack);
      begin repeat (24 * Q) @(negedge clk); host_wr(d1); end
    join
    chk("R10 header read ack", ack, 1);
    chk("R10 rw read", st_rw, 1);
    rbyte(1'b0, got);
    chk("R10 tx byte", got, d1);
    bstop();
    bstart();
    wbyte(HDR | 8'h01, ack);
    chk("R10 read refused after stop", ack, 0);
    bstop();
    bstart();
    wbyte(HDR, ack);
    host_adr(LOWB);
    wbyte(LOWB ^ 8'h01, ack);
    chk("R9 wrong low nack", ack, 0);
    bstop();

    // R11 disable
    ten_bit = 0;
    host_adr(OWN7);
    bstart();
    chk("R11 start before disable", st_start, 1);
    en = 0;
    repeat (3) @(negedge clk);
    chk("R11 flags cleared", {st_start, st_stop, sda_low}, 0);
    m_sda = 1; qwait(); m_scl = 1; qwait();
    bstart();
    wbyte(OWN7, ack);
    chk("R11 ignored addr", ack, 0);
    chk("R11 no start", st_start, 0);
    bstop();
    chk("R11 no stop", st_stop, 0);
    en = 1;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule